// File: doc/BRIEF.md
# Debounced GPIO Bank with Edge Interrupts

This block is a bank of general-purpose pins. Each pin presents a bidirectional buffer interface: an output level, a driver enable and an input level. Every input is brought into the core clock domain by a two-flop synchronizer. It then goes through a debounce filter whose sampling rate can be set anywhere from the core clock down to one sample every 128 clocks. The filter accepts a new level only when that level is seen at two sampling ticks in a row.

A change in the filtered level marks a rising or a falling event for that pin. Each event sets its own sticky status bit. The status bits are gated by an enable mask and ORed into a single interrupt request. A two-bit mode register decides who owns the pins. In mode 0 the pins are plain programmable I/O. Mode 1 and modes 2/3 hand the pin drivers to two alternate-function ports, which pass straight through this block.

Software reaches the state through a small register port. Writes take effect on the clock edge. Reads are combinational.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset, all driver enables, status bits and mask bits are 0, the interrupt output is 0, the mode is 0 and the rate code is 0.
- R2: In mode 0, the pin output levels and driver enables equal the data register (address 0) and the enable register (address 1), one bit per pin.
- R3: In mode 1, the pin levels and enables come from the first alternate port, and that port's input mirrors the pins. In modes 2 and 3 the second alternate port does the same. The mode register is at address 6, bits [1:0].
- R4: A read of address 2 returns the debounced level of every pin. With rate code 0, a stable change on a pin shows there after the fourth clock edge.
- R5: The filter moves its output only on a sampling tick, and only when that tick and the previous tick saw the same new level. With rate code 0, a pulse of one clock is ignored.
- R6: The rate code at address 5, bits [2:0], value n, produces one sampling tick every 2^n clocks. At n=3 a 5-clock pulse is ignored and a 30-clock pulse is accepted.
- R7: In the status register at address 4, a debounced rising edge of pin i sets bit i and a debounced falling edge sets bit NPIN+i.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. When a clear and a new event for the same bit fall on the same clock edge, the bit stays 1.
- R9: The mask register at address 3 uses the same bit layout as the status register, with 1 meaning enabled. The mask does not stop status bits from being set.
- R10: The interrupt output is 1 exactly when some status bit and its mask bit are both 1.
- R11: In modes other than 0, filtered transitions set no status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 2*NPIN | Write data |
| reg_rdata | output | 2*NPIN | Read data for reg_addr |
| pad_in | input | NPIN | Pin input buffers |
| pad_out | output | NPIN | Pin output levels |
| pad_oe | output | NPIN | Pin driver enables |
| alt1_out | input | NPIN | First alternate function output levels |
| alt1_oe | input | NPIN | First alternate function driver enables |
| alt1_in | output | NPIN | Pin levels seen by first alternate function |
| alt2_out | input | NPIN | Second alternate function output levels |
| alt2_oe | input | NPIN | Second alternate function driver enables |
| alt2_in | output | NPIN | Pin levels seen by second alternate function |
| irq | output | 1 | Combined masked interrupt request |

## Verification
The hardest case to reach is a software clear that falls on the same clock edge as a fresh event for the same status bit. The event edge sits four clock edges after the pin changes, counting two synchronizer flops, the previous-sample flop and the filter. The stimulus sets the rate code to 0 so that every clock is a sampling tick. It then changes the pin at a falling clock edge, lets three rising edges pass, and raises the clear write just ahead of the fourth edge. The bench also checks the debounce window at two rates, using pulses just below and well above the acceptance length.

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank #(
  parameter int NPIN = 8,
  parameter int CSW  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [2*NPIN-1:0] reg_wdata,
  output logic [2*NPIN-1:0] reg_rdata,
  input  logic [NPIN-1:0]   pad_in,
  output logic [NPIN-1:0]   pad_out,
  output logic [NPIN-1:0]   pad_oe,
  input  logic [NPIN-1:0]   alt1_out,
  input  logic [NPIN-1:0]   alt1_oe,
  output logic [NPIN-1:0]   alt1_in,
  input  logic [NPIN-1:0]   alt2_out,
  input  logic [NPIN-1:0]   alt2_oe,
  output logic [NPIN-1:0]   alt2_in,
  output logic              irq
);
  localparam int RW   = 2 * NPIN;
  localparam int DIVW = (1 << CSW) - 1;
  localparam logic [2:0] A_DOUT = 3'd0, A_OEN = 3'd1, A_DIN = 3'd2, A_MASK = 3'd3,
                         A_STAT = 3'd4, A_CSEL = 3'd5, A_MODE = 3'd6;

  logic [NPIN-1:0] dout_q, oen_q, s1, s2, smp, deb;
  logic [RW-1:0]   mask_q, st_q;
  logic [CSW-1:0]  csel_q;
  logic [1:0]      mode_q;
  logic [DIVW-1:0] divcnt;

  wire [DIVW-1:0] tmask = (DIVW'(1) << csel_q) - DIVW'(1);
  wire            tick  = (divcnt & tmask) == tmask;
  wire            pio   = (mode_q == 2'b00);
  wire [NPIN-1:0] acc   = tick ? ~(s2 ^ smp) : '0;
  wire [NPIN-1:0] rise  = acc & s2 & ~deb & {NPIN{pio}};
  wire [NPIN-1:0] fall  = acc & ~s2 & deb & {NPIN{pio}};
  wire [RW-1:0]   clr   = (reg_we && reg_addr == A_STAT) ? reg_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divcnt <= '0;
      s1 <= '0; s2 <= '0; smp <= '0; deb <= '0;
    end else begin
      divcnt <= divcnt + DIVW'(1);
      s1 <= pad_in;
      s2 <= s1;
      if (tick) smp <= s2;
      deb <= (deb & ~acc) | (s2 & acc);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0; oen_q <= '0; mask_q <= '0; st_q <= '0;
      csel_q <= '0; mode_q <= '0;
    end else begin
      st_q <= (st_q & ~clr) | {fall, rise};
      if (reg_we) begin
        case (reg_addr)
          A_DOUT: dout_q <= reg_wdata[NPIN-1:0];
          A_OEN:  oen_q  <= reg_wdata[NPIN-1:0];
          A_MASK: mask_q <= reg_wdata;
          A_CSEL: csel_q <= reg_wdata[CSW-1:0];
          A_MODE: mode_q <= reg_wdata[1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_DOUT: reg_rdata[NPIN-1:0] = dout_q;
      A_OEN:  reg_rdata[NPIN-1:0] = oen_q;
      A_DIN:  reg_rdata[NPIN-1:0] = deb;
      A_MASK: reg_rdata = mask_q;
      A_STAT: reg_rdata = st_q;
      A_CSEL: reg_rdata[CSW-1:0] = csel_q;
      A_MODE: reg_rdata[1:0] = mode_q;
      default: ;
    endcase
  end

  assign pad_out = pio ? dout_q : (mode_q == 2'b01) ? alt1_out : alt2_out;
  assign pad_oe  = pio ? oen_q  : (mode_q == 2'b01) ? alt1_oe  : alt2_oe;
  assign alt1_in = (mode_q == 2'b01) ? pad_in : '0;
  assign alt2_in = mode_q[1] ? pad_in : '0;
  assign irq     = |(st_q & mask_q);

  // R2: an enable write in mode 0 appears on the pins next cycle
  a_r2_oe_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_OEN && pio) |=> (!pio || pad_oe == $past(reg_wdata[NPIN-1:0])));

  // R5: filtered level never moves between ticks
  a_r5_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(deb));

  // R8: status bits only drop on a status write
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == A_STAT) |=> ((st_q & $past(st_q)) == $past(st_q)));

  // R11: alternate modes latch nothing
  a_r11_alt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!pio && !reg_we) |=> $stable(st_q));

  // R10: a raised request needs a set, enabled bit
  a_r10_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ((st_q & mask_q) != '0));
endmodule

// File: tb/sim_gpio_edge_bank.sv
module sim_gpio_edge_bank;
  localparam int N = 8;
  localparam int W = 2 * N;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [2:0] reg_addr = 0;
  logic [W-1:0] reg_wdata = 0, reg_rdata;
  logic [N-1:0] pad_in = 0, pad_out, pad_oe;
  logic [N-1:0] alt1_out = 0, alt1_oe = 0, alt1_in, alt2_out = 0, alt2_oe = 0, alt2_in;
  logic irq;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  gpio_edge_bank #(.NPIN(N)) u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [W-1:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [W-1:0] d);
    @(negedge clk); reg_addr = a; #0.1; d = reg_rdata;
  endtask

  task automatic idle(int c);
    repeat (c) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [W-1:0] d;
    @(negedge clk);
    chk("R1 oe", pad_oe, 0); chk("R1 irq", irq, 0);
    rd(3'd4, d); chk("R1 status", d, 0);
    rd(3'd3, d); chk("R1 mask", d, 0);
    rd(3'd6, d); chk("R1 mode", d, 0);
    rd(3'd5, d); chk("R1 rate", d, 0);
  endtask

  task automatic t_pio;
    wr(3'd0, 16'h00A5); wr(3'd1, 16'h00F0);
    @(negedge clk);
    chk("R2 out", pad_out, 8'hA5); chk("R2 oe", pad_oe, 8'hF0);
    wr(3'd1, 16'h0000);
  endtask

  task automatic t_alt;
    alt1_out = 8'h3C; alt1_oe = 8'hFF; alt2_out = 8'hC3; alt2_oe = 8'h0F; pad_in = 8'h81;
    wr(3'd6, 1);
    chk("R3 alt1 out", pad_out, 8'h3C); chk("R3 alt1 oe", pad_oe, 8'hFF);
    chk("R3 alt1 in", alt1_in, 8'h81);
    wr(3'd6, 2);
    chk("R3 alt2 out", pad_out, 8'hC3); chk("R3 alt2 oe", pad_oe, 8'h0F);
    chk("R3 alt2 in", alt2_in, 8'h81);
    idle(10);
    pad_in = 0; idle(10);
    wr(3'd6, 0);
    idle(5);
    chk("R3 back to pio oe", pad_oe, 8'h00);
  endtask

  task automatic t_alt_quiet;
    logic [W-1:0] d;
    wr(3'd4, '1);
    wr(3'd6, 3);
    pad_in = 8'h02; idle(12);
    rd(3'd2, d); chk("R11 filter still runs", d, 16'h0002);
    rd(3'd4, d); chk("R11 no edge latched", d, 0);
    pad_in = 0; idle(12);
    wr(3'd6, 0);
    rd(3'd4, d); chk("R11 no edge latched fall", d, 0);
  endtask

  task automatic t_latency_glitch;
    logic [W-1:0] d;
    // R4: pin change at negedge, visible after 4th posedge
    @(negedge clk); pad_in = 8'h10;
    repeat (3) @(posedge clk);
    @(negedge clk); reg_addr = 3'd2; #0.1; chk("R4 not yet", reg_rdata, 0);
    @(negedge clk); #0.1; chk("R4 after four edges", reg_rdata, 16'h0010);
    pad_in = 0; idle(8);
    wr(3'd4, '1);
    // R5: single-clock glitch ignored
    @(negedge clk); pad_in = 8'h01;
    @(negedge clk); pad_in = 8'h00;
    idle(8);
    rd(3'd2, d); chk("R5 glitch level", d, 0);
    rd(3'd4, d); chk("R5 glitch status", d, 0);
  endtask

  task automatic t_rate;
    logic [W-1:0] d;
    wr(3'd5, 3);
    pad_in = 8'h04; idle(5); pad_in = 0; idle(40);
    rd(3'd4, d); chk("R6 short pulse ignored", d, 0);
    pad_in = 8'h04; idle(28);
    rd(3'd2, d); chk("R6 long pulse level", d, 16'h0004);
    pad_in = 0; idle(30);
    rd(3'd4, d); chk("R6 long pulse edges", d, 16'h0404);
    wr(3'd4, '1);
    wr(3'd5, 0);
  endtask

  task automatic t_edges_w1c;
    logic [W-1:0] d;
    pad_in = 8'h01; idle(8);
    rd(3'd4, d); chk("R7 rise bit", d, 16'h0001);
    pad_in = 8'h00; idle(8);
    rd(3'd4, d); chk("R7 fall bit", d, 16'h0101);
    wr(3'd4, 16'h0100);
    rd(3'd4, d); chk("R8 clear one bit", d, 16'h0001);
    wr(3'd4, 16'h0000);
    rd(3'd4, d); chk("R8 zero write keeps", d, 16'h0001);
    pad_in = 8'h01; idle(8);
    pad_in = 8'h00; idle(8);
    wr(3'd4, '1);
    // R8: clear lands on the same edge as a new rise of pin 0
    @(negedge clk); pad_in = 8'h01;
    repeat (3) @(posedge clk);
    @(negedge clk); reg_we = 1; reg_addr = 3'd4; reg_wdata = 16'h0001;
    @(negedge clk); reg_we = 0;
    rd(3'd4, d); chk("R8 simultaneous set wins", d, 16'h0001);
    wr(3'd4, 16'h0001);
    rd(3'd4, d); chk("R8 later clear", d, 0);
    pad_in = 0; idle(8); wr(3'd4, '1);
  endtask

  task automatic t_mask_irq;
    logic [W-1:0] d;
    pad_in = 8'h08; idle(8);
    rd(3'd4, d); chk("R9 latched while masked", d, 16'h0008);
    chk("R10 masked irq low", irq, 0);
    wr(3'd3, 16'h0800);
    chk("R10 other bit enabled, irq low", irq, 0);
    wr(3'd3, 16'h0008);
    chk("R10 irq high", irq, 1);
    wr(3'd4, 16'h0008);
    chk("R10 irq drops on clear", irq, 0);
    pad_in = 0; idle(8);
    chk("R10 fall masked off", irq, 0);
    wr(3'd3, 16'h0800);
    chk("R10 fall enabled", irq, 1);
    wr(3'd4, '1); wr(3'd3, 0);
  endtask

  initial begin
    fork
      begin
        idle(3); rst_n = 1; idle(2);
        t_reset; t_pio; t_alt; t_alt_quiet; t_latency_glitch;
        t_rate; t_edges_w1c; t_mask_irq;
      end
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule